// File: doc/BRIEF.md
# Serial Character Transmitter with Commanded Line Break

This block serialises bytes onto a single asynchronous line using eight data bits, no parity and one stop bit. A one-entry holding register sits in front of a shift register, so software or a neighbouring engine can write the next byte while the current one is still going out. Successive bytes leave with no idle gap when the holding register is refilled before the stop bit ends. Bit timing comes from an external enable pulse, `tick16`, that fires at sixteen times the bit rate. Every change of line state is aligned to a bit boundary, which is the sixteenth counted pulse.

Two strobes drive a line break, meaning the line is held low for longer than a character. A break request never cuts a character short. It waits until the shift register and the holding register are both empty, and only then drives the line low. A release strobe returns the line high at the next bit boundary. The line then stays high for one complete guard bit before any queued byte may start.

The controller is a six-state machine:
- `ST_IDLE`: line high.
- `ST_START`: start bit, line low.
- `ST_DATA`: eight data bits, least significant first.
- `ST_STOP`: stop bit, line high.
- `ST_BREAK`: line held low.
- `ST_GUARD`: one marking bit after a break.

The transitions, each taken only at a bit boundary, are:
- `IDLE/STOP/GUARD -> START` when a byte is held and the transmitter is enabled.
- `IDLE/STOP/GUARD -> BREAK` when a break is pending and nothing is held.
- `IDLE/STOP/GUARD -> IDLE` otherwise.
- `START -> DATA`.
- `DATA -> DATA` for the next bit.
- `DATA -> STOP` after the eighth bit.
- `BREAK -> GUARD` once a release has been seen.

Top module: `sertx_brk`

## Requirements
- R1: After reset `txd` is 1, `hold_empty` is 1 and `tx_empty` is 1.
- R2: Each character goes out as one low start bit, then eight data bits with bit 0 first, then one high stop bit. Every bit lasts exactly 16 pulses of `tick16`.
- R3: Holding register and status flags:
  - `hold_empty` is 0 from the cycle after an accepted write until the byte moves into the shift register.
  - A write while the holding register is full, and not being emptied in that cycle, is ignored.
  - A byte written during a character starts right after that character's stop bit.
  - `tx_empty` is 1 only when the machine is idle and nothing is held.
- R4: While `tx_en` is 0, no new character starts. A held byte waits and is sent once `tx_en` returns to 1.
- R5: The line state changes only at bit boundaries. A byte written while idle starts within one bit time.
- R6: A break request while idle and enabled drives `txd` low within two bit times. The line stays low until a release.
- R7: A break request made during a character takes effect only after that character. It also waits for any byte in, or later written to, the holding register. The line goes low at the end of the last stop bit.
- R8: A break request while `tx_en` is 0 is discarded and not remembered.
- R9: A release strobe during a break drives `txd` high within two bit times.
- R10: After a break the line stays high for at least one full bit time (16 pulses) before a queued byte's start bit. That byte is then sent intact.
- R11: A release strobe that arrives before a pending break has begun cancels the break.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| tx_en | input | 1 | Transmitter enable level |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to write |
| brk_on_stb | input | 1 | Break request strobe |
| brk_off_stb | input | 1 | Break release strobe |
| txd | output | 1 | Serial line, high when marking |
| hold_empty | output | 1 | Holding register is empty |
| tx_empty | output | 1 | Nothing held and machine idle |

## Verification
The embedded properties check the following on every cycle:
- State moves only on a bit boundary.
- A break is entered only with an empty holding register.
- A break is always left through the guard state.
- A start bit always follows a marking bit, and only while enabled.
- A break request is latched only when it arrived while enabled.
- A full holding register keeps its byte against further writes.

Only the bench scenarios can show the following:
- The bit-exact framing of every byte value.
- The latency bounds of break entry and release.
- The ordering of queued bytes ahead of a deferred break.
- That a disabled request or a cancelled break leaves the line marking.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_BREAK,
        ST_GUARD
    } tx_state_e;

endpackage

// File: rtl/sertx_bittmr.sv
module sertx_bittmr #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick16,
    output logic bit_end
);

    localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    logic [CW-1:0] sub_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q <= '0;
        end else if (tick16) begin
            if (sub_q == LAST) begin
                sub_q <= '0;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    assign bit_end = tick16 && (sub_q == LAST);

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data
);

    logic          full_q;
    logic [DW-1:0] data_q;
    logic          accept;

    assign accept = wr_stb && (!full_q || take);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (accept) begin
                full_q <= 1'b1;
                data_q <= wr_data;
            end else if (take) begin
                full_q <= 1'b0;
            end
        end
    end

    assign full = full_q;
    assign data = data_q;

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && wr_stb && !take) |=> (full_q && $stable(data_q))); // R3

    AST_TAKE_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full_q); // R3

endmodule

// File: rtl/sertx_brkctl.sv
module sertx_brkctl (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic on_stb,
    input  logic off_stb,
    input  logic in_break,
    input  logic enter_break,
    input  logic leave_break,
    output logic brk_pend,
    output logic stop_pend
);

    logic brk_pend_q;
    logic stop_pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_pend_q  <= 1'b0;
            stop_pend_q <= 1'b0;
        end else begin
            if (off_stb || enter_break) begin
                brk_pend_q <= 1'b0;
            end else if (on_stb && tx_en && !in_break) begin
                brk_pend_q <= 1'b1;
            end

            if (leave_break) begin
                stop_pend_q <= 1'b0;
            end else if (off_stb && in_break) begin
                stop_pend_q <= 1'b1;
            end
        end
    end

    assign brk_pend  = brk_pend_q;
    assign stop_pend = stop_pend_q;

    AST_BRK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_pend_q) |-> $past(on_stb && tx_en)); // R8

    AST_RELEASE_IN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_pend_q) |-> $past(in_break)); // R9

endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_end,
    input  logic          tx_en,
    input  logic          hold_full,
    input  logic [DW-1:0] hold_data,
    input  logic          brk_pend,
    input  logic          stop_pend,
    output logic          take,
    output logic          enter_break,
    output logic          leave_break,
    output tx_state_e     state_o,
    output logic          txd
);

    localparam int IW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [IW-1:0] LAST_BIT = IW'(DW - 1);

    tx_state_e     state_q, state_d;
    logic [DW-1:0] shreg_q, shreg_d;
    logic [IW-1:0] idx_q,   idx_d;
    logic          txd_q;

    function automatic logic line_level(input tx_state_e st, input logic lsb);
        logic lv;
        unique case (st)
            ST_START, ST_BREAK: lv = 1'b0;
            ST_DATA:            lv = lsb;
            default:            lv = 1'b1;
        endcase
        return lv;
    endfunction

    // Next-state and datapath decisions, taken only on a bit boundary
    always_comb begin
        state_d     = state_q;
        shreg_d     = shreg_q;
        idx_d       = idx_q;
        take        = 1'b0;
        enter_break = 1'b0;
        leave_break = 1'b0;
        if (bit_end) begin
            unique case (state_q)
                ST_IDLE, ST_STOP, ST_GUARD: begin
                    if (hold_full && tx_en) begin
                        state_d = ST_START;
                        shreg_d = hold_data;
                        take    = 1'b1;
                    end else if (brk_pend && !hold_full) begin
                        state_d     = ST_BREAK;
                        enter_break = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
                ST_START: begin
                    state_d = ST_DATA;
                    idx_d   = '0;
                end
                ST_DATA: begin
                    shreg_d = shreg_q >> 1;
                    if (idx_q == LAST_BIT) begin
                        state_d = ST_STOP;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
                ST_BREAK: begin
                    if (stop_pend) begin
                        state_d     = ST_GUARD;
                        leave_break = 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            shreg_q <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            shreg_q <= shreg_d;
            idx_q   <= idx_d;
        end
    end

    // Output register, aligned with the state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd_q <= 1'b1;
        end else begin
            txd_q <= line_level(state_d, shreg_d[0]);
        end
    end

    assign txd     = txd_q;
    assign state_o = state_q;

    AST_MOVE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> $past(bit_end)); // R5

    AST_BREAK_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BREAK && $past(state_q) != ST_BREAK) |-> !$past(hold_full)); // R7

    AST_EXIT_VIA_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_BREAK && state_q != ST_BREAK) |-> (state_q == ST_GUARD)); // R10

    AST_START_FROM_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && $past(state_q) != ST_START) |-> $past(txd_q)); // R10

    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && $past(state_q) != ST_START) |-> $past(tx_en)); // R4

endmodule

// File: rtl/sertx_brk.sv
module sertx_brk
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              tx_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              brk_on_stb,
    input  logic              brk_off_stb,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_empty
);

    logic              bit_end;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              brk_pend;
    logic              stop_pend;
    logic              enter_break;
    logic              leave_break;
    tx_state_e         state;

    sertx_bittmr #(.OVS(OVS)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick16  (tick16),
        .bit_end (bit_end)
    );

    sertx_hold #(.DW(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    sertx_brkctl u_brk (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .on_stb      (brk_on_stb),
        .off_stb     (brk_off_stb),
        .in_break    (state == ST_BREAK),
        .enter_break (enter_break),
        .leave_break (leave_break),
        .brk_pend    (brk_pend),
        .stop_pend   (stop_pend)
    );

    sertx_fsm #(.DW(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_end     (bit_end),
        .tx_en       (tx_en),
        .hold_full   (hold_full),
        .hold_data   (hold_data),
        .brk_pend    (brk_pend),
        .stop_pend   (stop_pend),
        .take        (take),
        .enter_break (enter_break),
        .leave_break (leave_break),
        .state_o     (state),
        .txd         (txd)
    );

    assign hold_empty = !hold_full;
    assign tx_empty   = (state == ST_IDLE) && !hold_full;

endmodule

// File: tb/sertx_brk_tb.sv
module sertx_brk_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       tx_en = 1'b1;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       brk_on_stb = 1'b0;
    logic       brk_off_stb = 1'b0;
    logic       txd;
    logic       hold_empty;
    logic       tx_empty;

    int  n_chk = 0;
    int  n_bad = 0;
    int  tick_per = 1;
    int  tcnt = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    sertx_brk dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick16      (tick16),
        .tx_en       (tx_en),
        .wr_stb      (wr_stb),
        .wr_data     (wr_data),
        .brk_on_stb  (brk_on_stb),
        .brk_off_stb (brk_off_stb),
        .txd         (txd),
        .hold_empty  (hold_empty),
        .tx_empty    (tx_empty)
    );

    always @(negedge clk) begin
        if (tcnt >= tick_per - 1) begin
            tcnt   <= 0;
            tick16 <= 1'b1;
        end else begin
            tcnt   <= tcnt + 1;
            tick16 <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] v);
        @(negedge clk);
        wr_data = v;
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic pulse_on();
        @(negedge clk);
        brk_on_stb = 1'b1;
        @(negedge clk);
        brk_on_stb = 1'b0;
    endtask

    task automatic pulse_off();
        @(negedge clk);
        brk_off_stb = 1'b1;
        @(negedge clk);
        brk_off_stb = 1'b0;
    endtask

    task automatic wait_txd(input logic v, input int maxc, output int n);
        n = 0;
        while (txd !== v && n < maxc) begin
            @(negedge clk);
            n++;
        end
        if (txd !== v) n = -1;
    endtask

    task automatic count_low(input int cyc, output int lows);
        lows = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
    endtask

    task automatic rx_from_start(input int bc, output logic [7:0] b, output logic stopb);
        repeat (bc / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (bc) @(negedge clk);
            b[i] = txd;
        end
        repeat (bc) @(negedge clk);
        stopb = txd;
    endtask

    task automatic rx_byte(input int bc, output logic [7:0] b, output logic stopb, output int n);
        wait_txd(1'b0, 4 * bc, n);
        b = 8'h00;
        stopb = 1'b0;
        if (n >= 0) rx_from_start(bc, b, stopb);
    endtask

    initial begin
        logic [7:0] b;
        logic       sb;
        int         n;
        int         lows;

        repeat (5) @(negedge clk);
        // R1: reset state
        chk(txd === 1'b1, "R1", "txd in reset", int'(txd), 1);
        chk(hold_empty === 1'b1, "R1", "hold_empty in reset", int'(hold_empty), 1);
        chk(tx_empty === 1'b1, "R1", "tx_empty in reset", int'(tx_empty), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(txd === 1'b1 && tx_empty === 1'b1, "R1", "idle after reset",
            int'(txd & tx_empty), 1);

        // R2 sweep of every byte value; R5 start latency on the first one
        for (int v = 0; v < 256; v++) begin
            write_byte(8'(v));
            rx_byte(16, b, sb, n);
            if (v == 0) chk(n >= 0 && n <= 17, "R5", "start latency", n, 16);
            chk(b == 8'(v), "R2", "data byte", int'(b), v);
            chk(sb === 1'b1, "R2", "stop bit", int'(sb), 1);
            wait_txd(1'b1, 40, n);
        end
        repeat (20) @(negedge clk);
        chk(tx_empty === 1'b1, "R3", "tx_empty after sweep", int'(tx_empty), 1);

        // R2: slower tick, each bit spans 16 pulses = 48 clocks
        tick_per = 3;
        write_byte(8'hC3);
        rx_byte(48, b, sb, n);
        chk(b == 8'hC3 && sb === 1'b1, "R2", "byte at 1/3 tick rate", int'(b), 8'hC3);
        repeat (60) @(negedge clk);
        tick_per = 1;
        repeat (20) @(negedge clk);

        // R3 back-to-back: second byte written while first is shifting
        write_byte(8'h96);
        wait_txd(1'b0, 40, n);
        write_byte(8'h69);
        chk(hold_empty === 1'b0, "R3", "hold_empty after write", int'(hold_empty), 0);
        rx_from_start(16, b, sb);
        chk(b == 8'h96, "R3", "first of pair", int'(b), 8'h96);
        rx_byte(16, b, sb, n);
        chk(n >= 0 && n <= 9, "R3", "gap before second byte", n, 8);
        chk(b == 8'h69 && sb === 1'b1, "R3", "second of pair", int'(b), 8'h69);
        repeat (40) @(negedge clk);

        // R4 / R3: disabled transmitter holds byte; write while full ignored
        tx_en = 1'b0;
        write_byte(8'h77);
        chk(hold_empty === 1'b0 && tx_empty === 1'b0, "R3", "flags with byte held",
            int'(hold_empty | tx_empty), 0);
        write_byte(8'h88);
        count_low(64, lows);
        chk(lows == 0, "R4", "line quiet while disabled", lows, 0);
        tx_en = 1'b1;
        rx_byte(16, b, sb, n);
        chk(b == 8'h77, "R4", "held byte sent after enable", int'(b), 8'h77);
        count_low(60, lows);
        chk(lows == 0, "R3", "write while full ignored", lows, 0);
        chk(hold_empty === 1'b1 && tx_empty === 1'b1, "R3", "flags after drain",
            int'(hold_empty & tx_empty), 1);

        // R8: break request while disabled is discarded
        tx_en = 1'b0;
        pulse_on();
        tx_en = 1'b1;
        count_low(60, lows);
        chk(lows == 0, "R8", "disabled break request not remembered", lows, 0);

        // R6 / R9 / R10: break from idle, byte queued during break, guard bit
        pulse_on();
        wait_txd(1'b0, 40, n);
        chk(n >= 0 && n <= 32, "R6", "break entry latency", n, 16);
        repeat (50) @(negedge clk);
        chk(txd === 1'b0, "R6", "break persists", int'(txd), 0);
        write_byte(8'hA5);
        count_low(40, lows);
        chk(lows == 40, "R10", "no byte during break", lows, 40);
        pulse_off();
        wait_txd(1'b1, 40, n);
        chk(n >= 0 && n <= 32, "R9", "release latency", n, 16);
        wait_txd(1'b0, 40, n);
        chk(n >= 16, "R10", "guard bit length", n, 16);
        rx_from_start(16, b, sb);
        chk(b == 8'hA5 && sb === 1'b1, "R10", "byte after guard", int'(b), 8'hA5);
        repeat (40) @(negedge clk);

        // R7: request during a character waits for its end
        write_byte(8'h3C);
        wait_txd(1'b0, 40, n);
        pulse_on();
        rx_from_start(16, b, sb);
        chk(b == 8'h3C && sb === 1'b1, "R7", "in-flight byte intact", int'(b), 8'h3C);
        wait_txd(1'b0, 16, n);
        chk(n >= 0, "R7", "break after stop bit", n, 8);
        repeat (30) @(negedge clk);
        pulse_off();
        wait_txd(1'b1, 40, n);
        repeat (40) @(negedge clk);

        // R7: request with a byte also held waits for both
        write_byte(8'h11);
        wait_txd(1'b0, 40, n);
        write_byte(8'h22);
        pulse_on();
        rx_from_start(16, b, sb);
        chk(b == 8'h11, "R7", "first byte before break", int'(b), 8'h11);
        rx_byte(16, b, sb, n);
        chk(n >= 0 && n <= 9 && b == 8'h22 && sb === 1'b1, "R7", "held byte before break",
            int'(b), 8'h22);
        wait_txd(1'b0, 16, n);
        chk(n >= 0, "R7", "break after held byte", n, 8);
        pulse_off();
        wait_txd(1'b1, 40, n);
        chk(n >= 0, "R9", "release after deferred break", n, 16);
        repeat (40) @(negedge clk);

        // R11: release before the break begins cancels it
        write_byte(8'h5A);
        wait_txd(1'b0, 40, n);
        pulse_on();
        pulse_off();
        rx_from_start(16, b, sb);
        chk(b == 8'h5A, "R11", "byte before cancelled break", int'(b), 8'h5A);
        count_low(60, lows);
        chk(lows == 0, "R11", "cancelled break leaves line high", lows, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog (all): actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule